// File: doc/BRIEF.md
# Inclusive Write-Back Second-Level Cache

This block is a unified, set-associative second-level cache. It sits between a split first-level cache and main memory. The instruction side issues line reads through its own port. The data side issues word reads and word writes through another port, and its write-through stores all arrive here. Both sides share one tag/data array and one line-wide path to memory. A store updates only this cache and marks the line dirty. A store that misses first brings in the whole line and then merges the word into it.

The block keeps strict inclusion over the level above. Before a resident line is replaced, the block sends back-invalidate pulses to both first-level caches, one for each first-level block the line covers. Each line holds two first-level blocks. After those pulses, a dirty victim goes out to memory as one full-line write, and only then is the refill read issued. Every data write also pulses an instruction-side invalidate for the first-level block it touches, so that stale code cannot survive a store. When both sides ask in the same cycle, the data side is served first and the instruction side waits. At elaboration the block refuses a geometry that cannot hold the level above: it needs at least as many sets and at least as many ways.

Top module: `l2_cache`

## Requirements
- R1: A read that hits raises the ack of the requesting port one cycle after the request is accepted, with the addressed 32-bit word on that port's read-data output. Address bits [1:0] select the word in the line, bits [3:2] select the set, and bits [11:4] form the tag.
- R2: A read miss to a set whose chosen way is empty issues one memory read of the line address (word address bits [11:2]). The ack follows 3 cycles after acceptance when memory answers at once, and carries the word taken from the refilled line.
- R3: A write hit updates only the cached word and marks the line dirty. It causes no memory access, and a later read returns the new word.
- R4: A write miss first refills the whole line from memory, then merges the written word. The other three words keep their memory values.
- R5: A dirty victim is written to memory as one full line at its own line address, and this happens before the refill read is issued. A miss with a dirty victim acks 7 cycles after acceptance.
- R6: Each set has its own round-robin pointer. A refill uses the way the pointer names, and the pointer then moves on to the next way, wrapping after the last.
- R7: Replacing a valid line first raises both back-invalidate outputs for two consecutive cycles. The first cycle carries the victim's lower first-level block address and the second carries the upper one, where a block address is word address bits [11:1]. A clean victim adds two cycles, so the ack comes 5 cycles after acceptance.
- R8: Every data write, hit or miss, pulses only the instruction-side invalidate for one cycle, in its ack cycle, with the written word's block address.
- R9: When both ports request in the same cycle, the data request is served first. The instruction port gets no ack until the data port has been acknowledged.
- R10: After reset every line is invalid, so the first access to any address misses. All acks, memory requests and invalidates are low while no request is pending.
- R11: Elaboration fails unless the set count is at least the first-level set count and the way count is at least the first-level way count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ic_req_i | input | 1 | Instruction-side request, held until acked |
| ic_addr_i | input | 12 | Instruction-side word address |
| ic_ack_o | output | 1 | Instruction-side completion pulse |
| ic_rdata_o | output | 32 | Instruction-side read word |
| dc_req_i | input | 1 | Data-side request, held until acked |
| dc_we_i | input | 1 | Data-side write enable |
| dc_addr_i | input | 12 | Data-side word address |
| dc_wdata_i | input | 32 | Data-side write word |
| dc_ack_o | output | 1 | Data-side completion pulse |
| dc_rdata_o | output | 32 | Data-side read word |
| mem_req_o | output | 1 | Memory request, held until mem_ack_i |
| mem_we_o | output | 1 | Memory write (line write-back) |
| mem_addr_o | output | 10 | Memory line address |
| mem_wdata_o | output | 128 | Line written back, word 0 in bits [31:0] |
| mem_ack_i | input | 1 | Memory completion, one cycle |
| mem_rdata_i | input | 128 | Refill line, word 0 in bits [31:0] |
| binv_ic_o | output | 1 | Back-invalidate to the instruction cache |
| binv_dc_o | output | 1 | Back-invalidate to the data cache |
| binv_addr_o | output | 11 | Block address being invalidated |

## Verification
With a memory that answers the cycle after it sees a request, the acks are due at set times after acceptance: 1 cycle on a hit, 3 cycles on a miss into an empty way, 5 when a clean victim must be invalidated, and 7 when a dirty victim must also be written back. The bench predicts each of these latencies from its own behavioural cache model before it drives a request. It then counts falling edges until the ack and samples every output on those falling edges. On every cycle of a transaction it records the invalidate pulses and the write-backs the memory responder sees. At the ack it compares that ordered record with the model's predicted list, which catches an invalidate or write-back that is missing, extra or in the wrong order.

// File: rtl/l2_pkg.sv
package l2_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_INV,
    ST_WB,
    ST_FILL
  } l2_state_e;
endpackage

// File: rtl/l2_tag_array.sv
module l2_tag_array #(
  parameter int SETS  = 4,
  parameter int WAYS  = 2,
  parameter int TAG_W = 8,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] set_i,
  input  logic [TAG_W-1:0] tag_i,
  output logic             hit_o,
  output logic [WAY_W-1:0] hit_way_o,
  input  logic [WAY_W-1:0] vic_way_i,
  output logic             vic_valid_o,
  output logic             vic_dirty_o,
  output logic [TAG_W-1:0] vic_tag_o,
  input  logic             fill_i,
  input  logic [WAY_W-1:0] fill_way_i,
  input  logic             dirty_i,
  input  logic [WAY_W-1:0] dirty_way_i
);
  logic [TAG_W-1:0] tag_q   [SETS][WAYS];
  logic [WAYS-1:0]  valid_q [SETS];
  logic [WAYS-1:0]  dirty_q [SETS];
  logic [WAYS-1:0]  hit_vec;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = valid_q[set_i][w] && (tag_q[set_i][w] == tag_i);
  end

  always_comb begin
    hit_way_o = '0;
    for (int w = 0; w < WAYS; w++)
      if (hit_vec[w]) hit_way_o = WAY_W'(w);
  end

  assign hit_o       = |hit_vec;
  assign vic_valid_o = valid_q[set_i][vic_way_i];
  assign vic_dirty_o = dirty_q[set_i][vic_way_i];
  assign vic_tag_o   = tag_q[set_i][vic_way_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        dirty_q[s] <= '0;
      end
    end else if (fill_i) begin
      valid_q[set_i][fill_way_i] <= 1'b1;
      dirty_q[set_i][fill_way_i] <= 1'b0;
    end else if (dirty_i) begin
      dirty_q[set_i][dirty_way_i] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (fill_i) tag_q[set_i][fill_way_i] <= tag_i;
  end

  // R1: a tag may live in at most one way of a set
  a_r1_single_hit: assert property (@(posedge clk_i) disable iff (!rst_ni) $onehot0(hit_vec));
endmodule

// File: rtl/l2_data_array.sv
module l2_data_array #(
  parameter int SETS   = 4,
  parameter int WAYS   = 2,
  parameter int DATA_W = 32,
  parameter int WORDS  = 4,
  localparam int IDX_W  = $clog2(SETS),
  localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int WRD_W  = $clog2(WORDS),
  localparam int LINE_W = WORDS * DATA_W
) (
  input  logic              clk_i,
  input  logic [IDX_W-1:0]  set_i,
  input  logic [WAY_W-1:0]  way_i,
  output logic [LINE_W-1:0] line_o,
  input  logic              fill_i,
  input  logic [LINE_W-1:0] fill_line_i,
  input  logic              wr_i,
  input  logic [WRD_W-1:0]  wr_word_i,
  input  logic [DATA_W-1:0] wr_data_i
);
  logic [LINE_W-1:0] data_q [SETS][WAYS];

  assign line_o = data_q[set_i][way_i];

  always_ff @(posedge clk_i) begin
    if (fill_i) data_q[set_i][way_i] <= fill_line_i;
    else if (wr_i) data_q[set_i][way_i][wr_word_i*DATA_W +: DATA_W] <= wr_data_i;
  end
endmodule

// File: rtl/l2_rr_ptr.sv
module l2_rr_ptr #(
  parameter int SETS = 4,
  parameter int WAYS = 2,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] set_i,
  input  logic             adv_i,
  output logic [WAY_W-1:0] way_o
);
  localparam logic [WAY_W-1:0] LAST = WAY_W'(WAYS - 1);
  logic [WAY_W-1:0] ptr_q [SETS];

  assign way_o = ptr_q[set_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) ptr_q[s] <= '0;
    end else if (adv_i) begin
      ptr_q[set_i] <= (ptr_q[set_i] == LAST) ? '0 : ptr_q[set_i] + 1'b1;
    end
  end
endmodule

// File: rtl/l2_cache.sv
module l2_cache
  import l2_pkg::*;
#(
  parameter int ADDR_W       = 12,
  parameter int DATA_W       = 32,
  parameter int SETS         = 4,
  parameter int WAYS         = 2,
  parameter int L1_BLK_WORDS = 2,
  parameter int L1_SETS      = 4,
  parameter int L1_WAYS      = 1,
  localparam int L1_PER_LINE = 2,
  localparam int LINE_WORDS  = L1_PER_LINE * L1_BLK_WORDS,
  localparam int OFF_W       = $clog2(LINE_WORDS),
  localparam int BOFF_W      = $clog2(L1_BLK_WORDS),
  localparam int IDX_W       = $clog2(SETS),
  localparam int TAG_W       = ADDR_W - IDX_W - OFF_W,
  localparam int LINE_W      = LINE_WORDS * DATA_W,
  localparam int LA_W        = ADDR_W - OFF_W,
  localparam int BA_W        = ADDR_W - BOFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ic_req_i,
  input  logic [ADDR_W-1:0] ic_addr_i,
  output logic              ic_ack_o,
  output logic [DATA_W-1:0] ic_rdata_o,
  input  logic              dc_req_i,
  input  logic              dc_we_i,
  input  logic [ADDR_W-1:0] dc_addr_i,
  input  logic [DATA_W-1:0] dc_wdata_i,
  output logic              dc_ack_o,
  output logic [DATA_W-1:0] dc_rdata_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [LA_W-1:0]   mem_addr_o,
  output logic [LINE_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [LINE_W-1:0] mem_rdata_i,
  output logic              binv_ic_o,
  output logic              binv_dc_o,
  output logic [BA_W-1:0]   binv_addr_o
);
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int CNT_W = $clog2(L1_PER_LINE);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(L1_PER_LINE - 1);

  // R11: inclusion is only possible if this level is at least as wide and as deep
  if (SETS < L1_SETS || WAYS < L1_WAYS) begin : g_incl_chk
    $error("l2_cache: sets and ways must cover the first level");
  end

  l2_state_e         state_q;
  logic              is_d_q, we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [WAY_W-1:0]  vway_q;

  logic [IDX_W-1:0]  req_set;
  logic [TAG_W-1:0]  req_tag;
  logic [OFF_W-1:0]  req_word;
  logic              hit, vic_valid, vic_dirty;
  logic [WAY_W-1:0]  hit_way, rr_way, vic_way, dat_way;
  logic [TAG_W-1:0]  vic_tag;
  logic [LINE_W-1:0] line_rd;
  logic              look_hit, wr_hit, fill_done;
  logic [DATA_W-1:0] rd_word;

  assign req_set  = addr_q[OFF_W +: IDX_W];
  assign req_tag  = addr_q[ADDR_W-1 -: TAG_W];
  assign req_word = addr_q[OFF_W-1:0];

  assign look_hit  = (state_q == ST_LOOKUP) && hit;
  assign wr_hit    = look_hit && is_d_q && we_q;
  assign fill_done = (state_q == ST_FILL) && mem_ack_i;
  assign vic_way   = (state_q == ST_LOOKUP) ? rr_way : vway_q;
  assign dat_way   = (state_q == ST_LOOKUP) ? hit_way : vway_q;

  l2_tag_array #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) i_tags (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .set_i       (req_set),
    .tag_i       (req_tag),
    .hit_o       (hit),
    .hit_way_o   (hit_way),
    .vic_way_i   (vic_way),
    .vic_valid_o (vic_valid),
    .vic_dirty_o (vic_dirty),
    .vic_tag_o   (vic_tag),
    .fill_i      (fill_done),
    .fill_way_i  (vway_q),
    .dirty_i     (wr_hit),
    .dirty_way_i (hit_way)
  );

  l2_data_array #(.SETS(SETS), .WAYS(WAYS), .DATA_W(DATA_W), .WORDS(LINE_WORDS)) i_data (
    .clk_i       (clk_i),
    .set_i       (req_set),
    .way_i       (dat_way),
    .line_o      (line_rd),
    .fill_i      (fill_done),
    .fill_line_i (mem_rdata_i),
    .wr_i        (wr_hit),
    .wr_word_i   (req_word),
    .wr_data_i   (wdata_q)
  );

  l2_rr_ptr #(.SETS(SETS), .WAYS(WAYS)) i_rr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (req_set),
    .adv_i  (fill_done),
    .way_o  (rr_way)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      is_d_q  <= 1'b0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      cnt_q   <= '0;
      vway_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (dc_req_i) begin  // data side wins ties
            is_d_q  <= 1'b1;
            we_q    <= dc_we_i;
            addr_q  <= dc_addr_i;
            wdata_q <= dc_wdata_i;
            state_q <= ST_LOOKUP;
          end else if (ic_req_i) begin
            is_d_q  <= 1'b0;
            we_q    <= 1'b0;
            addr_q  <= ic_addr_i;
            state_q <= ST_LOOKUP;
          end
        end
        ST_LOOKUP: begin
          if (hit) begin
            state_q <= ST_IDLE;
          end else begin
            vway_q  <= rr_way;
            cnt_q   <= '0;
            state_q <= vic_valid ? ST_INV : ST_FILL;
          end
        end
        ST_INV: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CNT_LAST) state_q <= vic_dirty ? ST_WB : ST_FILL;
        end
        ST_WB:   if (mem_ack_i) state_q <= ST_FILL;
        ST_FILL: if (mem_ack_i) state_q <= ST_LOOKUP;  // replay as a hit
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rd_word    = line_rd[req_word*DATA_W +: DATA_W];
  assign ic_ack_o   = look_hit && !is_d_q;
  assign dc_ack_o   = look_hit && is_d_q;
  assign ic_rdata_o = rd_word;
  assign dc_rdata_o = rd_word;

  assign mem_req_o   = (state_q == ST_WB) || (state_q == ST_FILL);
  assign mem_we_o    = (state_q == ST_WB);
  assign mem_addr_o  = (state_q == ST_WB) ? {vic_tag, req_set} : addr_q[ADDR_W-1:OFF_W];
  assign mem_wdata_o = line_rd;

  assign binv_dc_o   = (state_q == ST_INV);
  assign binv_ic_o   = (state_q == ST_INV) || wr_hit;
  assign binv_addr_o = (state_q == ST_INV) ? {vic_tag, req_set, cnt_q} : addr_q[ADDR_W-1:BOFF_W];

  a_r9_data_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && dc_req_i && ic_req_i) |=> (state_q == ST_LOOKUP && is_d_q));

  a_r5_wb_then_refill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o && mem_ack_i) |=> (mem_req_o && !mem_we_o));

  a_r7_inv_block_pair: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (binv_dc_o && !binv_addr_o[0]) |=> (binv_dc_o && binv_addr_o[0]));

  a_r2_refill_then_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o && mem_ack_i) |=> (ic_ack_o || dc_ack_o));

  a_r8_write_inv_ic_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dc_ack_o && we_q) |-> (binv_ic_o && !binv_dc_o));
endmodule

// File: tb/test_l2_cache.sv
module test_l2_cache;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic ic_req = 0, dc_req = 0, dc_we = 0, mem_ack = 0;
  logic [11:0] ic_addr = '0, dc_addr = '0;
  logic [31:0] dc_wdata = '0;
  logic [127:0] mem_rdata = '0;
  logic ic_ack, dc_ack, mem_req, mem_we, binv_ic, binv_dc;
  logic [31:0] ic_rdata, dc_rdata;
  logic [9:0] mem_addr;
  logic [127:0] mem_wdata;
  logic [10:0] binv_addr;

  l2_cache i_l2_cache (
    .clk_i(clk), .rst_ni(rst_n),
    .ic_req_i(ic_req), .ic_addr_i(ic_addr), .ic_ack_o(ic_ack), .ic_rdata_o(ic_rdata),
    .dc_req_i(dc_req), .dc_we_i(dc_we), .dc_addr_i(dc_addr), .dc_wdata_i(dc_wdata),
    .dc_ack_o(dc_ack), .dc_rdata_o(dc_rdata),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
    .binv_ic_o(binv_ic), .binv_dc_o(binv_dc), .binv_addr_o(binv_addr)
  );

  int checks = 0, errors = 0;

  // memory seen by the design, and the model's own idea of memory
  logic [31:0] mem [int];
  logic [31:0] ref_mem [int];
  logic [137:0] got_wb [$];
  logic [137:0] exp_wb [$];
  logic [12:0] got_inv [$];
  logic [12:0] exp_inv [$];

  // behavioural cache model: 4 sets, 2 ways, 4 words per line
  int          m_tag [4][2];
  bit          m_val [4][2];
  bit          m_dirty [4][2];
  logic [31:0] m_data [4][2][4];
  int          m_rr [4];

  function automatic logic [31:0] init_word(int a);
    return 32'hC0DE0000 | 32'(a);
  endfunction

  function automatic logic [31:0] rd_mem(int a);
    return mem.exists(a) ? mem[a] : init_word(a);
  endfunction

  function automatic logic [31:0] rd_ref(int a);
    return ref_mem.exists(a) ? ref_mem[a] : init_word(a);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [137:0] act, input logic [137:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // memory responder: one-cycle ack the cycle after a request is seen
  always @(negedge clk) begin
    if (mem_ack) mem_ack = 1'b0;
    else if (mem_req) begin
      mem_ack = 1'b1;
      if (mem_we) begin
        got_wb.push_back({mem_addr, mem_wdata});
        for (int k = 0; k < 4; k++) mem[{mem_addr, 2'(k)}] = mem_wdata[k*32 +: 32];
      end else begin
        for (int k = 0; k < 4; k++) mem_rdata[k*32 +: 32] = rd_mem({mem_addr, 2'(k)});
      end
    end
  end

  task automatic predict(input bit we, input logic [11:0] a, input logic [31:0] wd,
                         output logic [31:0] rd, output int lat);
    int s, t, w, hw;
    bit hit;
    s = int'(a[3:2]); t = int'(a[11:4]); w = int'(a[1:0]);
    hit = 0; hw = 0;
    for (int v = 0; v < 2; v++)
      if (m_val[s][v] && m_tag[s][v] == t) begin hit = 1; hw = v; end
    lat = 1;
    if (!hit) begin
      hw = m_rr[s];
      lat = 3;
      if (m_val[s][hw]) begin
        lat = 5;
        exp_inv.push_back({2'b11, 8'(m_tag[s][hw]), 2'(s), 1'b0});
        exp_inv.push_back({2'b11, 8'(m_tag[s][hw]), 2'(s), 1'b1});
        if (m_dirty[s][hw]) begin
          logic [127:0] ln;
          lat = 7;
          for (int k = 0; k < 4; k++) begin
            ln[k*32 +: 32] = m_data[s][hw][k];
            ref_mem[{8'(m_tag[s][hw]), 2'(s), 2'(k)}] = m_data[s][hw][k];
          end
          exp_wb.push_back({8'(m_tag[s][hw]), 2'(s), ln});
        end
      end
      for (int k = 0; k < 4; k++) m_data[s][hw][k] = rd_ref({a[11:2], 2'(k)});
      m_tag[s][hw] = t; m_val[s][hw] = 1; m_dirty[s][hw] = 0;
      m_rr[s] = (m_rr[s] + 1) % 2;
    end
    if (we) begin
      m_data[s][hw][w] = wd;
      m_dirty[s][hw] = 1;
      exp_inv.push_back({2'b10, a[11:1]});
    end
    rd = m_data[s][hw][w];
  endtask

  task automatic clear_q();
    got_inv.delete(); exp_inv.delete(); got_wb.delete(); exp_wb.delete();
  endtask

  task automatic cmp_q(input string req);
    chk(got_inv.size() == exp_inv.size(), req, "invalidate count",
        138'(got_inv.size()), 138'(exp_inv.size()));
    for (int k = 0; k < got_inv.size() && k < exp_inv.size(); k++)
      chk(got_inv[k] == exp_inv[k], req, "invalidate {ic,dc,addr}",
          138'(got_inv[k]), 138'(exp_inv[k]));
    chk(got_wb.size() == exp_wb.size(), req, "write-back count",
        138'(got_wb.size()), 138'(exp_wb.size()));
    for (int k = 0; k < got_wb.size() && k < exp_wb.size(); k++)
      chk(got_wb[k] == exp_wb[k], req, "write-back {addr,line}", got_wb[k], exp_wb[k]);
  endtask

  task automatic run(input bit is_d, input bit we, input logic [11:0] a,
                     input logic [31:0] wd, input string req);
    logic [31:0] erd;
    int elat, cyc;
    bit other, seen;
    clear_q();
    predict(we, a, wd, erd, elat);
    @(negedge clk);
    if (is_d) begin dc_req = 1; dc_we = we; dc_addr = a; dc_wdata = wd; end
    else begin ic_req = 1; ic_addr = a; end
    cyc = 0; other = 0; seen = 0;
    while (!seen && cyc < 40) begin
      @(negedge clk);
      cyc++;
      if (binv_ic || binv_dc) got_inv.push_back({binv_ic, binv_dc, binv_addr});
      if (is_d ? ic_ack : dc_ack) other = 1;
      if (is_d ? dc_ack : ic_ack) seen = 1;
    end
    dc_req = 0; ic_req = 0; dc_we = 0;
    chk(seen && cyc == elat, req, "ack latency", 138'(cyc), 138'(elat));
    if (!we) chk((is_d ? dc_rdata : ic_rdata) == erd, req, "read word",
                 138'(is_d ? dc_rdata : ic_rdata), 138'(erd));
    chk(!other, "R10", "other port acked", 138'(other), 138'(0));
    cmp_q(req);
  endtask

  task automatic run_both(input logic [11:0] ia, input logic [11:0] da,
                          input logic [31:0] dwd);
    logic [31:0] drd, ird;
    int dlat, ilat, cyc;
    bit ddone, idone, early;
    clear_q();
    predict(1'b1, da, dwd, drd, dlat);
    predict(1'b0, ia, '0, ird, ilat);
    @(negedge clk);
    dc_req = 1; dc_we = 1; dc_addr = da; dc_wdata = dwd;
    ic_req = 1; ic_addr = ia;
    cyc = 0; ddone = 0; idone = 0; early = 0;
    while (!idone && cyc < 60) begin
      @(negedge clk);
      cyc++;
      if (binv_ic || binv_dc) got_inv.push_back({binv_ic, binv_dc, binv_addr});
      if (ic_ack && !ddone) early = 1;
      if (ic_ack) begin
        idone = 1; ic_req = 0;
        chk(ic_rdata == ird, "R9", "stalled fetch word", 138'(ic_rdata), 138'(ird));
      end
      if (dc_ack) begin
        chk(cyc == dlat, "R9", "data side latency", 138'(cyc), 138'(dlat));
        ddone = 1; dc_req = 0; dc_we = 0;
      end
    end
    ic_req = 0; dc_req = 0;
    chk(ddone && idone && !early, "R9", "data before fetch", 138'(early), 138'(0));
    cmp_q("R9");
  endtask

  initial begin
    for (int s = 0; s < 4; s++) begin
      m_rr[s] = 0;
      for (int v = 0; v < 2; v++) begin m_val[s][v] = 0; m_dirty[s][v] = 0; m_tag[s][v] = 0; end
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!ic_ack && !dc_ack && !mem_req && !binv_ic && !binv_dc, "R10", "quiet after reset",
        138'({ic_ack, dc_ack, mem_req, binv_ic, binv_dc}), 138'(0));

    run(1, 0, 12'h010, '0, "R2");              // cold miss into empty way
    run(1, 0, 12'h011, '0, "R1");              // data read hit
    run(0, 0, 12'h013, '0, "R1");              // fetch hit
    run(1, 1, 12'h012, 32'hDEAD0001, "R8");    // write hit, ic invalidate
    run(1, 0, 12'h012, '0, "R3");              // new word visible
    run(1, 1, 12'h020, 32'hBEEF0002, "R4");    // write miss allocates
    run(1, 0, 12'h022, '0, "R4");              // rest of line from memory
    run(1, 0, 12'h030, '0, "R5");              // dirty victim way 0
    run(1, 0, 12'h040, '0, "R6");              // pointer moved to way 1
    run(0, 0, 12'h012, '0, "R5");              // written-back word returns
    run(1, 0, 12'h044, '0, "R2");              // other set, empty way
    run(1, 0, 12'h054, '0, "R2");
    run(1, 0, 12'h064, '0, "R7");              // clean valid victim
    run_both(12'h058, 12'h05A, 32'h12345678);  // same cycle, data first

    begin
      int lf = 32'h1ACE;
      for (int n = 0; n < 60; n++) begin
        logic [11:0] a;
        lf = (lf * 1103515245 + 12345) & 32'h7fffffff;
        a = {4'h0, 4'((lf >> 8) % 6), 2'(lf >> 4), 2'(lf >> 2)};
        run(((lf >> 16) % 4) != 0, ((lf >> 20) % 3) == 0 && ((lf >> 16) % 4) != 0,
            a, 32'(lf), "R6");
      end
    end
    run(0, 0, 12'h001, '0, "R1");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule